// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block keeps account of a controller's on-chip packet memory. The memory is split into a small pool of equal packet slots, and each slot holds one packet. The block does not move packet data. It only decides which slot number a packet may use and when that slot becomes free again. The host drives a single command port with four operations: claim a slot, queue a slot for transmission, give back the oldest received slot, and wipe the pool. A busy flag covers each command for a fixed number of cycles. The effect of the command appears when that flag drops.

Slot numbers move through two ordered queues. The transmit queue holds slots the host has handed to the MAC. When the MAC reports a finished transmission, the head of that queue leaves. If automatic freeing is on, its slot also goes back to the pool. The receive queue holds slots that the MAC filled with arriving packets. It reports whether anything is waiting. Two sticky interrupt flags are provided, one for a granted slot and one for a drained transmit queue. The host clears each flag with a one-cycle acknowledge pulse. A count of free slots, in units of one slot (2048 bytes), is always visible.

Top module: `pkt_page_alloc`

## Requirements
- R1: After reset every slot is free (`free_units` = 4), `busy`, `alloc_irq`, `alloc_failed`, `txe_irq` and `tx_head_valid` are 0 and `rx_empty` is 1.
- R2: A command is taken only at a clock edge where `cmd_valid` is 1 and `busy` is 0. `cmd_op` encodes 0 = claim, 1 = enqueue, 2 = release, 3 = pool reset. `busy` is then high for exactly 2 cycles, and the command's results show in the cycle in which `busy` is low again. Any command presented while `busy` is high is dropped without effect.
- R3: A claim that succeeds grants the lowest-numbered free slot. It writes that slot number to `alloc_pnum`, clears `alloc_failed` and sets `alloc_irq`.
- R4: A claim fails in either of two cases: no slot is free, or the page field `cmd_pages` (256-byte pages needed minus one) is 8 or more, so the packet would not fit a 2048-byte slot. A failed claim sets `alloc_failed`, writes 0 to `alloc_pnum`, leaves the pool unchanged and does not set `alloc_irq`.
- R5: `alloc_irq` stays set until a cycle with `alloc_irq_ack` high clears it. `txe_irq` behaves the same way with `txe_irq_ack`. A new set in the same cycle as an acknowledge wins.
- R6: `free_units` always equals the number of free slots, one unit per 2048-byte slot.
- R7: An enqueue command appends `cmd_pnum` to the transmit queue. `tx_head_valid` and `tx_head_pnum` show the oldest entry, in arrival order.
- R8: A `tx_done` pulse while the transmit queue is not empty removes its head. If `autorel_en` is 1, the head's slot is returned to the pool. If the removal leaves the queue empty, `txe_irq` is set.
- R9: With `autorel_en` at 0, a `tx_done` pulse removes the head but the slot stays allocated.
- R10: A `rx_push` pulse marks slot `rx_push_pnum` as used and appends it to the receive queue. `rx_empty` drops and `rx_head_pnum` shows the oldest entry.
- R11: A release command frees the slot at the head of the receive queue and removes that entry. A release while the receive queue is empty changes nothing.
- R12: A pool reset command frees all slots and empties both queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code (0 claim, 1 enqueue, 2 release, 3 pool reset) |
| cmd_pages | input | 8 | Claim size: 256-byte pages needed minus one |
| cmd_pnum | input | 2 | Slot number for an enqueue command |
| busy | output | 1 | High while a command is in progress |
| alloc_pnum | output | 2 | Slot granted by the last claim |
| alloc_failed | output | 1 | Last claim could not be granted |
| alloc_irq | output | 1 | Sticky flag for a granted claim |
| alloc_irq_ack | input | 1 | Clears `alloc_irq` |
| autorel_en | input | 1 | Free slots automatically on transmit completion |
| tx_done | input | 1 | MAC finished sending the transmit queue head |
| tx_head_valid | output | 1 | Transmit queue holds an entry |
| tx_head_pnum | output | 2 | Slot at the transmit queue head |
| txe_irq | output | 1 | Sticky flag for a drained transmit queue |
| txe_irq_ack | input | 1 | Clears `txe_irq` |
| rx_push | input | 1 | MAC stored a received packet |
| rx_push_pnum | input | 2 | Slot holding that packet |
| rx_empty | output | 1 | Receive queue is empty |
| rx_head_pnum | output | 2 | Slot at the receive queue head |
| free_units | output | 8 | Free slots, one unit per 2048 bytes |

## Verification
A corrupt free mask shows at the ports within one command. `free_units` then disagrees with the count of grants minus releases, and the next claim returns a slot other than the lowest one that should be free. A wrong busy counter shows as a busy window that is not exactly two cycles, or as a second command that gets through while busy. A broken queue pointer shows at the next queue event: the heads come out in the wrong order, or the empty indications are wrong. The checks therefore sample every port in the cycle right after each command completes and right after each MAC pulse.

// File: rtl/pa_pkg.sv
// Shared command encoding for the packet page allocator.
package pa_pkg;
    typedef enum logic [1:0] {
        OP_ALLOC   = 2'd0,
        OP_ENQUEUE = 2'd1,
        OP_RELEASE = 2'd2,
        OP_RESET   = 2'd3
    } pa_op_e;
endpackage

// File: rtl/pa_cmd_ctrl.sv
// Command front end: accepts one command when idle, holds busy for
// BUSY_CYCLES cycles and pulses exec in the last one with the latched
// operands. Assumes BUSY_CYCLES >= 1; commands seen while busy are dropped.
module pa_cmd_ctrl
    import pa_pkg::*;
#(
    parameter int BUSY_CYCLES = 2,
    parameter int PG_W        = 8,
    parameter int PNUM_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [PG_W-1:0]   cmd_pages,
    input  logic [PNUM_W-1:0] cmd_pnum,
    output logic              busy,
    output logic              exec,
    output pa_op_e            exec_op,
    output logic [PG_W-1:0]   exec_pages,
    output logic [PNUM_W-1:0] exec_pnum
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          accept;

    assign busy   = (cnt_q != '0);
    assign exec   = (cnt_q == CW'(1));
    assign accept = cmd_valid && !busy;

    // Busy window counter: load on accept, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (busy)       cnt_q <= cnt_q - CW'(1);
        else if (cmd_valid)  cnt_q <= CW'(BUSY_CYCLES);
    end

    // Operand latch captured at the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exec_op    <= OP_ALLOC;
            exec_pages <= '0;
            exec_pnum  <= '0;
        end else if (accept) begin
            exec_op    <= pa_op_e'(cmd_op);
            exec_pages <= cmd_pages;
            exec_pnum  <= cmd_pnum;
        end
    end
endmodule

// File: rtl/pa_free_map.sv
// Free-slot bitmap: one bit per slot, 1 = free. Offers the lowest free
// slot and a population count. A release beats nothing; a claim of the
// same slot in the same cycle wins over its release; reset_all wins over both.
module pa_free_map #(
    parameter int NUM_SLOTS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reset_all,
    input  logic [NUM_SLOTS-1:0]         claim_mask,
    input  logic [NUM_SLOTS-1:0]         release_mask,
    output logic                         grant_valid,
    output logic [$clog2(NUM_SLOTS)-1:0] grant_idx,
    output logic [$clog2(NUM_SLOTS+1)-1:0] free_count
);
    localparam int IW = $clog2(NUM_SLOTS);
    localparam int CW = $clog2(NUM_SLOTS + 1);

    logic [NUM_SLOTS-1:0] free_q;

    // Bitmap update with reset, release and claim priority.
    always_ff @(posedge clk) begin
        if (!rst_n || reset_all) free_q <= '1;
        else                     free_q <= (free_q | release_mask) & ~claim_mask;
    end

    // Lowest free slot search and free count.
    always_comb begin
        grant_idx  = '0;
        free_count = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (free_q[i]) grant_idx = IW'(i);
        end
        for (int i = 0; i < NUM_SLOTS; i++) begin
            free_count = free_count + CW'(free_q[i]);
        end
    end

    assign grant_valid = |free_q;
endmodule

// File: rtl/pa_pnum_fifo.sv
// Ordered queue of slot numbers. Push and pop may share a cycle; a push
// into a full queue without a pop is dropped; clear empties it at once.
module pa_pnum_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic          do_push, do_pop;

    assign do_pop  = pop && (count != '0);
    assign do_push = push && ((count != CW'(DEPTH)) || do_pop);
    assign head    = mem_q[rd_q];
    assign empty   = (count == '0);

    // Entry storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= push_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
            if (do_pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/pkt_page_alloc.sv
// Packet buffer page allocator top. Ties the command front end, free map
// and the transmit/receive slot queues together and owns the result and
// interrupt registers. Assumes the MAC only pushes received packets into
// slots that are free and only signals tx_done for the queue head.
module pkt_page_alloc
    import pa_pkg::*;
#(
    parameter int NUM_SLOTS   = 4,
    parameter int SLOT_BYTES  = 2048,
    parameter int PAGE_BYTES  = 256,
    parameter int BUSY_CYCLES = 2,
    parameter int PG_W        = 8,
    parameter int FU_W        = 8,
    parameter int PNUM_W      = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [PG_W-1:0]   cmd_pages,
    input  logic [PNUM_W-1:0] cmd_pnum,
    output logic              busy,
    output logic [PNUM_W-1:0] alloc_pnum,
    output logic              alloc_failed,
    output logic              alloc_irq,
    input  logic              alloc_irq_ack,
    input  logic              autorel_en,
    input  logic              tx_done,
    output logic              tx_head_valid,
    output logic [PNUM_W-1:0] tx_head_pnum,
    output logic              txe_irq,
    input  logic              txe_irq_ack,
    input  logic              rx_push,
    input  logic [PNUM_W-1:0] rx_push_pnum,
    output logic              rx_empty,
    output logic [PNUM_W-1:0] rx_head_pnum,
    output logic [FU_W-1:0]   free_units
);
    localparam int CW = $clog2(NUM_SLOTS + 1);
    localparam logic [PG_W:0] SLOT_PAGES = (PG_W + 1)'(SLOT_BYTES / PAGE_BYTES);

    logic              exec;
    pa_op_e            exec_op;
    logic [PG_W-1:0]   exec_pages;
    logic [PNUM_W-1:0] exec_pnum;
    logic              grant_valid;
    logic [PNUM_W-1:0] grant_idx;
    logic [CW-1:0]     free_count;
    logic              tx_empty;
    logic [CW-1:0]     tx_count;
    logic [CW-1:0]     rx_count;
    logic              do_alloc, fits, grant_ok, do_enq, do_rel, do_rst, tx_pop;
    logic [NUM_SLOTS-1:0] claim_mask, release_mask;

    pa_cmd_ctrl #(.BUSY_CYCLES(BUSY_CYCLES), .PG_W(PG_W), .PNUM_W(PNUM_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pages(cmd_pages), .cmd_pnum(cmd_pnum), .busy(busy), .exec(exec),
        .exec_op(exec_op), .exec_pages(exec_pages), .exec_pnum(exec_pnum)
    );

    // Decode of the completing command and MAC events.
    always_comb begin
        do_alloc = exec && (exec_op == OP_ALLOC);
        fits     = ({1'b0, exec_pages} < SLOT_PAGES);
        grant_ok = do_alloc && fits && grant_valid;
        do_enq   = exec && (exec_op == OP_ENQUEUE);
        do_rel   = exec && (exec_op == OP_RELEASE) && !rx_empty;
        do_rst   = exec && (exec_op == OP_RESET);
        tx_pop   = tx_done && !tx_empty;
    end

    // Slot claim and release masks fed to the free map.
    always_comb begin
        claim_mask   = '0;
        release_mask = '0;
        if (grant_ok)             claim_mask[grant_idx]      = 1'b1;
        if (rx_push)              claim_mask[rx_push_pnum]   = 1'b1;
        if (do_rel)               release_mask[rx_head_pnum] = 1'b1;
        if (tx_pop && autorel_en) release_mask[tx_head_pnum] = 1'b1;
    end

    pa_free_map #(.NUM_SLOTS(NUM_SLOTS)) u_map (
        .clk(clk), .rst_n(rst_n), .reset_all(do_rst), .claim_mask(claim_mask),
        .release_mask(release_mask), .grant_valid(grant_valid),
        .grant_idx(grant_idx), .free_count(free_count)
    );

    pa_pnum_fifo #(.DEPTH(NUM_SLOTS), .W(PNUM_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .clear(do_rst), .push(do_enq),
        .push_data(exec_pnum), .pop(tx_pop), .head(tx_head_pnum),
        .empty(tx_empty), .count(tx_count)
    );

    pa_pnum_fifo #(.DEPTH(NUM_SLOTS), .W(PNUM_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clear(do_rst), .push(rx_push),
        .push_data(rx_push_pnum), .pop(do_rel), .head(rx_head_pnum),
        .empty(rx_empty), .count(rx_count)
    );

    // Claim result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_pnum   <= '0;
            alloc_failed <= 1'b0;
        end else if (do_alloc) begin
            alloc_pnum   <= grant_ok ? grant_idx : '0;
            alloc_failed <= !grant_ok;
        end
    end

    // Sticky interrupt flags; a new set beats an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_irq <= 1'b0;
            txe_irq   <= 1'b0;
        end else begin
            if (grant_ok)           alloc_irq <= 1'b1;
            else if (alloc_irq_ack) alloc_irq <= 1'b0;
            if (tx_pop && (tx_count == CW'(1)) && !do_enq && !do_rst) txe_irq <= 1'b1;
            else if (txe_irq_ack)   txe_irq <= 1'b0;
        end
    end

    assign tx_head_valid = !tx_empty;
    assign free_units    = FU_W'(free_count);

    logic unused_ok;
    assign unused_ok = ^rx_count;
endmodule

// File: rtl/pkt_page_alloc_chk.sv
// Property checker for the packet page allocator, bound to the top.
module pkt_page_alloc_chk
    import pa_pkg::*;
#(
    parameter int NUM_SLOTS   = 4,
    parameter int BUSY_CYCLES = 2,
    parameter int FU_W        = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [1:0]      cmd_op,
    input logic            busy,
    input logic            alloc_irq,
    input logic            alloc_failed,
    input logic            tx_head_valid,
    input logic            rx_empty,
    input logic [FU_W-1:0] free_units
);
    localparam int RW = $clog2(BUSY_CYCLES + 2);

    logic [RW-1:0] run_q;
    logic [1:0]    op_q;

    // Length of the current busy run, counted in the checker.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + RW'(1);
        else           run_q <= '0;
    end

    // Operation of the command most recently taken.
    always_ff @(posedge clk) begin
        if (!rst_n)                    op_q <= 2'd0;
        else if (cmd_valid && !busy)   op_q <= cmd_op;
    end

    // R2: a busy run never exceeds its fixed length.
    p_busy_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < RW'(BUSY_CYCLES)));

    // R2: a busy run ends exactly at its fixed length.
    p_busy_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(run_q) == RW'(BUSY_CYCLES - 1)));

    // R3: a grant flag only rises when a command completes, and never as a failure.
    p_irq_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alloc_irq) |-> ($fell(busy) && !alloc_failed));

    // R6: free count stays within the pool size.
    p_free_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        free_units <= FU_W'(NUM_SLOTS));

    // R12: a pool reset leaves every slot free and both queues empty.
    p_pool_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && (op_q == OP_RESET)) |->
        ((free_units == FU_W'(NUM_SLOTS)) && rx_empty && !tx_head_valid));
endmodule

bind pkt_page_alloc pkt_page_alloc_chk #(
    .NUM_SLOTS(NUM_SLOTS), .BUSY_CYCLES(BUSY_CYCLES), .FU_W(FU_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .alloc_irq(alloc_irq), .alloc_failed(alloc_failed),
    .tx_head_valid(tx_head_valid), .rx_empty(rx_empty), .free_units(free_units)
);

// File: tb/tb_pkt_page_alloc.sv
// Directed bench for the packet page allocator: one task per scenario.
module tb_pkt_page_alloc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] cmd_pages = 8'd0;
    logic [1:0] cmd_pnum = 2'd0;
    logic       alloc_irq_ack = 1'b0, autorel_en = 1'b1, tx_done = 1'b0;
    logic       txe_irq_ack = 1'b0, rx_push = 1'b0;
    logic [1:0] rx_push_pnum = 2'd0;
    logic       busy, alloc_failed, alloc_irq, tx_head_valid, txe_irq, rx_empty;
    logic [1:0] alloc_pnum, tx_head_pnum, rx_head_pnum;
    logic [7:0] free_units;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pkt_page_alloc dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_pages(cmd_pages), .cmd_pnum(cmd_pnum), .busy(busy),
        .alloc_pnum(alloc_pnum), .alloc_failed(alloc_failed), .alloc_irq(alloc_irq),
        .alloc_irq_ack(alloc_irq_ack), .autorel_en(autorel_en), .tx_done(tx_done),
        .tx_head_valid(tx_head_valid), .tx_head_pnum(tx_head_pnum), .txe_irq(txe_irq),
        .txe_irq_ack(txe_irq_ack), .rx_push(rx_push), .rx_push_pnum(rx_push_pnum),
        .rx_empty(rx_empty), .rx_head_pnum(rx_head_pnum), .free_units(free_units)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Present one command for one edge, then wait until it completes.
    task automatic issue(input logic [1:0] op, input logic [7:0] pg, input logic [1:0] pn);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_pages = pg; cmd_pnum = pn;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_tx_done();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic pulse_rx(input logic [1:0] pn);
        @(negedge clk); rx_push = 1'b1; rx_push_pnum = pn;
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic ack_alloc();
        @(negedge clk); alloc_irq_ack = 1'b1;
        @(negedge clk); alloc_irq_ack = 1'b0;
    endtask

    task automatic ack_txe();
        @(negedge clk); txe_irq_ack = 1'b1;
        @(negedge clk); txe_irq_ack = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1 free_units", free_units, 4);
        check("R1 busy", busy, 0);
        check("R1 alloc_irq", alloc_irq, 0);
        check("R1 alloc_failed", alloc_failed, 0);
        check("R1 txe_irq", txe_irq, 0);
        check("R1 tx_head_valid", tx_head_valid, 0);
        check("R1 rx_empty", rx_empty, 1);
    endtask

    task automatic t_first_claim();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_pages = 8'd4;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R2 busy first cycle", busy, 1);
        @(negedge clk);
        check("R2 busy second cycle", busy, 1);
        check("R2 no result yet", alloc_irq, 0);
        @(negedge clk);
        check("R2 busy cleared", busy, 0);
        check("R3 lowest slot", alloc_pnum, 0);
        check("R3 not failed", alloc_failed, 0);
        check("R3 irq set", alloc_irq, 1);
        check("R6 free after claim", free_units, 3);
        ack_alloc();
        check("R5 irq cleared by ack", alloc_irq, 0);
    endtask

    task automatic t_busy_drop();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_pages = 8'd0;
        @(negedge clk);
        cmd_op = 2'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        repeat (3) @(negedge clk);
        check("R2 second claim dropped", free_units, 2);
        check("R3 grant slot 1", alloc_pnum, 1);
        ack_alloc();
    endtask

    task automatic t_fill_and_fail();
        issue(2'd0, 8'd7, 2'd0);
        check("R3 grant slot 2", alloc_pnum, 2);
        issue(2'd0, 8'd0, 2'd0);
        check("R3 grant slot 3", alloc_pnum, 3);
        check("R6 pool empty", free_units, 0);
        ack_alloc();
        issue(2'd0, 8'd0, 2'd0);
        check("R4 failed when full", alloc_failed, 1);
        check("R4 pnum zero on fail", alloc_pnum, 0);
        check("R4 no irq on fail", alloc_irq, 0);
    endtask

    task automatic t_autorelease();
        autorel_en = 1'b1;
        issue(2'd1, 8'd0, 2'd2);
        issue(2'd1, 8'd0, 2'd0);
        check("R7 head valid", tx_head_valid, 1);
        check("R7 head oldest", tx_head_pnum, 2);
        pulse_tx_done();
        check("R8 next head", tx_head_pnum, 0);
        check("R8 slot freed", free_units, 1);
        check("R8 no txe yet", txe_irq, 0);
        pulse_tx_done();
        check("R8 queue drained", tx_head_valid, 0);
        check("R8 second slot freed", free_units, 2);
        check("R8 txe set", txe_irq, 1);
        ack_txe();
        check("R5 txe cleared", txe_irq, 0);
        issue(2'd0, 8'd1, 2'd0);
        check("R3 lowest freed slot", alloc_pnum, 0);
        check("R6 free after reclaim", free_units, 1);
        ack_alloc();
    endtask

    task automatic t_no_autorelease();
        autorel_en = 1'b0;
        issue(2'd1, 8'd0, 2'd0);
        pulse_tx_done();
        check("R9 head removed", tx_head_valid, 0);
        check("R9 slot kept", free_units, 1);
        ack_txe();
        autorel_en = 1'b1;
    endtask

    task automatic t_pool_reset();
        issue(2'd1, 8'd0, 2'd1);
        pulse_rx(2'd3);
        issue(2'd3, 8'd0, 2'd0);
        check("R12 all free", free_units, 4);
        check("R12 tx empty", tx_head_valid, 0);
        check("R12 rx empty", rx_empty, 1);
    endtask

    task automatic t_receive();
        pulse_rx(2'd1);
        check("R10 slot claimed", free_units, 3);
        check("R10 rx not empty", rx_empty, 0);
        check("R10 rx head", rx_head_pnum, 1);
        pulse_rx(2'd3);
        check("R10 second claimed", free_units, 2);
        check("R10 head unchanged", rx_head_pnum, 1);
        issue(2'd0, 8'd0, 2'd0);
        check("R3 skips rx slot", alloc_pnum, 0);
        issue(2'd0, 8'd0, 2'd0);
        check("R3 next free slot", alloc_pnum, 2);
        ack_alloc();
        issue(2'd2, 8'd0, 2'd0);
        check("R11 head advances", rx_head_pnum, 3);
        check("R11 slot freed", free_units, 1);
        issue(2'd2, 8'd0, 2'd0);
        check("R11 queue empty", rx_empty, 1);
        check("R11 second freed", free_units, 2);
        issue(2'd2, 8'd0, 2'd0);
        check("R11 empty release no effect", free_units, 2);
        check("R11 still empty", rx_empty, 1);
    endtask

    task automatic t_oversize();
        issue(2'd0, 8'd0, 2'd0);
        check("R3 grant slot 1 again", alloc_pnum, 1);
        ack_alloc();
        issue(2'd0, 8'd8, 2'd0);
        check("R4 oversize failed", alloc_failed, 1);
        check("R4 oversize pool unchanged", free_units, 1);
        check("R4 oversize no irq", alloc_irq, 0);
        issue(2'd0, 8'd7, 2'd0);
        check("R4 largest fitting size", alloc_pnum, 3);
        check("R4 fit not failed", alloc_failed, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_first_claim();
        t_busy_drop();
        t_fill_and_fail();
        t_autorelease();
        t_no_autorelease();
        t_pool_reset();
        t_receive();
        t_oversize();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule